// File: doc/BRIEF.md
# Interruptible Banked Block-Copy Engine

This block copies a run of words from one place in memory to another, one word at a time, over a simple synchronous memory port. Software first fills five operand registers through a small select/write/readback interface: a source pointer (low word plus a short high field), a word count, and a destination pointer (low word plus high field). It then pulses `start`. The engine saves the current bank register and loads a new bank value built from the two high fields. It then loops: it tests the count, reads a source word, and stores that word at the destination. Whenever the engine stops, the saved bank value is put back.

After every stored word the engine samples an interrupt request. If a request is pending and interrupts are enabled, the engine stops early and pulses `intr`. The operand registers then hold the advanced pointers and the reduced count. Pulsing `start` again continues the copy, with no word written twice and none skipped. When the count runs out, the engine pulses `done`. The high bank field selects the upper address bits for reads, and the low bank field selects them for writes.

Top module: `bcopy_engine`

## Requirements
- R1: Operand select codes are 0 source low, 1 source high, 2 count, 3 destination low, 4 destination high and 5 bank. While the engine is idle, `opr_we` writes `opr_wdata` into the selected register. `opr_rdata` shows the selected register zero-extended in the same cycle. After reset every register reads 0, and `busy`, `done`, `intr` and `mem_req` are low.
- R2: While `busy` is high, `start` and `opr_we` have no effect. The running copy keeps its length and timing, and the operands are not overwritten.
- R3: On the edge that accepts `start`, the engine saves the old bank value. From the next cycle `bank` equals source high × 4 + destination high, that is {source high, destination high}.
- R4: A start with count 0 makes no memory access and pulses `done` in the second cycle after the accepting edge.
- R5: Each word takes four cycles when read data returns one cycle after the request. The engine reads at {bank[3:2], source low}, then writes that data to {bank[1:0], destination low}, and decrements the count by one. For a count of N with no interrupt, `done` is seen 4N+1 cycles after the first busy cycle.
- R6: Each word advances both low pointers by one, modulo 2^16. A wrap from 0xFFFF to 0x0000 leaves the high fields unchanged.
- R7: If `irq_req` and `irq_en` are both high in the cycle that stores a word, the engine stops after that word. It pulses `intr` in the next cycle, with the pointers and count left updated for that word.
- R8: `irq_req` with `irq_en` low has no effect on the copy or its timing.
- R9: Restarting after an interrupt continues from the saved operands. The destination ends up holding every source word exactly once.
- R10: On both the `done` exit and the `intr` exit, `bank` already holds the saved value during the pulse cycle. `bank` does not change while the copy runs.
- R11: `done` and `intr` are one-cycle pulses that are never high together. `busy` is high from the cycle after the accepting edge through the pulse cycle.
- R12: At most one access is outstanding: no request is issued in the cycle right after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin or resume a copy (ignored while busy) |
| busy | output | 1 | Engine is running |
| done | output | 1 | One-cycle pulse: count exhausted |
| intr | output | 1 | One-cycle pulse: stopped by interrupt |
| opr_we | input | 1 | Operand write strobe |
| opr_sel | input | 3 | Operand select code |
| opr_wdata | input | DATA_W | Operand write value |
| opr_rdata | output | DATA_W | Selected operand value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | HI_W+ADDR_W | Banked memory address |
| mem_wdata | output | DATA_W | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| irq_req | input | 1 | Interrupt pending |
| irq_en | input | 1 | Interrupts enabled |
| bank | output | 2*HI_W | Bank register |

## Verification
Each `start` is driven on a falling edge. From the first busy cycle, the bench counts falling edges and expects the exit pulse at one exact count: 1 for an empty copy, 4N+1 for N words, and 4 for a copy stopped by an interrupt. The bank value is sampled in the first busy cycle and again in the pulse cycle. Operands and memory are read back only after the exit pulse. The memory model returns read data exactly one cycle after each request, so every word keeps the fixed four-cycle cadence.

// File: rtl/bcopy_pkg.sv
package bcopy_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TEST,
      ST_READ,
      ST_WAIT,
      ST_WRITE,
      ST_DONE,
      ST_INTR
   } bc_state_e;

   localparam int unsigned SEL_W = 3;

   localparam logic [SEL_W-1:0] SEL_SRC_LO = 3'd0;
   localparam logic [SEL_W-1:0] SEL_SRC_HI = 3'd1;
   localparam logic [SEL_W-1:0] SEL_COUNT  = 3'd2;
   localparam logic [SEL_W-1:0] SEL_DST_LO = 3'd3;
   localparam logic [SEL_W-1:0] SEL_DST_HI = 3'd4;
   localparam logic [SEL_W-1:0] SEL_BANK   = 3'd5;

endpackage

// File: rtl/bcopy_seq.sv
module bcopy_seq
   import bcopy_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic cnt_zero,
   input  logic mem_rvalid,
   input  logic irq_req,
   input  logic irq_en,
   output logic swap_en,
   output logic restore_en,
   output logic dec_cnt,
   output logic bump_src,
   output logic bump_dst,
   output logic cap_data,
   output logic mem_req,
   output logic mem_we,
   output logic busy,
   output logic done,
   output logic intr
);

   bc_state_e state_q, state_d;

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d    = state_q;
      swap_en    = 1'b0;
      restore_en = 1'b0;
      dec_cnt    = 1'b0;
      bump_src   = 1'b0;
      bump_dst   = 1'b0;
      cap_data   = 1'b0;
      mem_req    = 1'b0;
      mem_we     = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               swap_en = 1'b1;
               state_d = ST_TEST;
            end
         end
         ST_TEST: begin
            if (cnt_zero) begin
               restore_en = 1'b1;
               state_d    = ST_DONE;
            end else begin
               dec_cnt = 1'b1;
               state_d = ST_READ;
            end
         end
         ST_READ: begin
            mem_req  = 1'b1;
            bump_src = 1'b1;
            state_d  = ST_WAIT;
         end
         ST_WAIT: begin
            if (mem_rvalid) begin
               cap_data = 1'b1;
               state_d  = ST_WRITE;
            end
         end
         ST_WRITE: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            bump_dst = 1'b1;
            if (irq_req && irq_en) begin
               restore_en = 1'b1;
               state_d    = ST_INTR;
            end else begin
               state_d = ST_TEST;
            end
         end
         ST_DONE: state_d = ST_IDLE;
         ST_INTR: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   assign busy = (state_q != ST_IDLE);
   assign done = (state_q == ST_DONE);
   assign intr = (state_q == ST_INTR);

endmodule

// File: rtl/bcopy_regs.sv
module bcopy_regs
   import bcopy_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned HI_W   = 2,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [SEL_W-1:0]  sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              dec_cnt,
   input  logic [1:0]        bump,
   input  logic              cap_data,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] src_lo,
   output logic [HI_W-1:0]   src_hi,
   output logic [ADDR_W-1:0] dst_lo,
   output logic [HI_W-1:0]   dst_hi,
   output logic              cnt_zero,
   output logic [DATA_W-1:0] data_q,
   output logic [DATA_W-1:0] rd_val
);

   logic [ADDR_W-1:0] lo_w [2];
   logic [HI_W-1:0]   hi_w [2];
   logic [CNT_W-1:0]  cnt_q;

   // Pointer pair: index 0 is the source, index 1 the destination.
   for (genvar p = 0; p < 2; p++) begin : g_ptr
      localparam logic [SEL_W-1:0] LO_SEL = (p == 0) ? SEL_SRC_LO : SEL_DST_LO;
      localparam logic [SEL_W-1:0] HI_SEL = (p == 0) ? SEL_SRC_HI : SEL_DST_HI;
      logic [ADDR_W-1:0] lo_q;
      logic [HI_W-1:0]   hi_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
         end else begin
            if (ld_en && sel == LO_SEL) lo_q <= wdata[ADDR_W-1:0];
            else if (bump[p])           lo_q <= lo_q + 1'b1;
            if (ld_en && sel == HI_SEL) hi_q <= wdata[HI_W-1:0];
         end
      end

      assign lo_w[p] = lo_q;
      assign hi_w[p] = hi_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (ld_en && sel == SEL_COUNT)  cnt_q <= wdata[CNT_W-1:0];
      else if (dec_cnt)                    cnt_q <= cnt_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        data_q <= '0;
      else if (cap_data) data_q <= mem_rdata;
   end

   assign src_lo   = lo_w[0];
   assign src_hi   = hi_w[0];
   assign dst_lo   = lo_w[1];
   assign dst_hi   = hi_w[1];
   assign cnt_zero = (cnt_q == '0);

   always_comb begin
      case (sel)
         SEL_SRC_LO: rd_val = DATA_W'(lo_w[0]);
         SEL_SRC_HI: rd_val = DATA_W'(hi_w[0]);
         SEL_COUNT:  rd_val = DATA_W'(cnt_q);
         SEL_DST_LO: rd_val = DATA_W'(lo_w[1]);
         SEL_DST_HI: rd_val = DATA_W'(hi_w[1]);
         default:    rd_val = '0;
      endcase
   end

endmodule

// File: rtl/bcopy_bank.sv
module bcopy_bank #(
   parameter int unsigned HI_W   = 2,
   localparam int unsigned BANK_W = 2 * HI_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [BANK_W-1:0] wdata,
   input  logic              swap_en,
   input  logic              restore_en,
   input  logic [HI_W-1:0]   src_hi,
   input  logic [HI_W-1:0]   dst_hi,
   output logic [BANK_W-1:0] bank_q
);

   logic [BANK_W-1:0] saved_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_q  <= '0;
         saved_q <= '0;
      end else if (swap_en) begin
         saved_q <= bank_q;
         bank_q  <= {src_hi, dst_hi};
      end else if (restore_en) begin
         bank_q <= saved_q;
      end else if (ld_en) begin
         bank_q <= wdata;
      end
   end

endmodule

// File: rtl/bcopy_engine.sv
module bcopy_engine
   import bcopy_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned HI_W   = 2,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 16,
   localparam int unsigned BANK_W = 2 * HI_W,
   localparam int unsigned MA_W   = HI_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic              intr,
   input  logic              opr_we,
   input  logic [SEL_W-1:0]  opr_sel,
   input  logic [DATA_W-1:0] opr_wdata,
   output logic [DATA_W-1:0] opr_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [MA_W-1:0]   mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              irq_req,
   input  logic              irq_en,
   output logic [BANK_W-1:0] bank
);

   if (ADDR_W > DATA_W || CNT_W > DATA_W || BANK_W > DATA_W) begin : g_bad_width
      $error("bcopy_engine: operand fields must fit in DATA_W");
   end
   if (HI_W < 1 || ADDR_W < 2 || CNT_W < 1) begin : g_bad_size
      $error("bcopy_engine: field widths too small");
   end

   logic              swap_en, restore_en, dec_cnt, bump_src, bump_dst, cap_data;
   logic              cnt_zero, ld_en;
   logic [ADDR_W-1:0] src_lo, dst_lo;
   logic [HI_W-1:0]   src_hi, dst_hi;
   logic [DATA_W-1:0] data_q, rd_val;

   assign ld_en = opr_we && !busy;

   bcopy_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .cnt_zero   (cnt_zero),
      .mem_rvalid (mem_rvalid),
      .irq_req    (irq_req),
      .irq_en     (irq_en),
      .swap_en    (swap_en),
      .restore_en (restore_en),
      .dec_cnt    (dec_cnt),
      .bump_src   (bump_src),
      .bump_dst   (bump_dst),
      .cap_data   (cap_data),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .busy       (busy),
      .done       (done),
      .intr       (intr)
   );

   bcopy_regs #(
      .ADDR_W (ADDR_W),
      .HI_W   (HI_W),
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_en     (ld_en),
      .sel       (opr_sel),
      .wdata     (opr_wdata),
      .dec_cnt   (dec_cnt),
      .bump      ({bump_dst, bump_src}),
      .cap_data  (cap_data),
      .mem_rdata (mem_rdata),
      .src_lo    (src_lo),
      .src_hi    (src_hi),
      .dst_lo    (dst_lo),
      .dst_hi    (dst_hi),
      .cnt_zero  (cnt_zero),
      .data_q    (data_q),
      .rd_val    (rd_val)
   );

   bcopy_bank #(
      .HI_W (HI_W)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_en      (ld_en && opr_sel == SEL_BANK),
      .wdata      (opr_wdata[BANK_W-1:0]),
      .swap_en    (swap_en),
      .restore_en (restore_en),
      .src_hi     (src_hi),
      .dst_hi     (dst_hi),
      .bank_q     (bank)
   );

   assign opr_rdata = (opr_sel == SEL_BANK) ? DATA_W'(bank) : rd_val;
   assign mem_addr  = mem_we ? {bank[HI_W-1:0], dst_lo}
                             : {bank[BANK_W-1:HI_W], src_lo};
   assign mem_wdata = data_q;

endmodule

// File: rtl/bcopy_engine_chk.sv
module bcopy_engine_chk #(
   parameter int unsigned BANK_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              intr,
   input logic              mem_req,
   input logic              mem_we,
   input logic              irq_en,
   input logic [BANK_W-1:0] bank
);

   // R11: exit pulses are exclusive and last one cycle
   a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && intr));
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r11_intr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      intr |=> !intr);

   // R12: nothing is requested in the cycle following a read request
   a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |=> !mem_req);

   // R2: no memory traffic while idle
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   // R10: the bank value holds while a copy runs
   a_r10_bank_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !done && !intr) |-> $stable(bank));

   // R8: an interrupt exit requires the enable in the storing cycle
   a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      intr |-> $past(irq_en));

endmodule

bind bcopy_engine bcopy_engine_chk #(.BANK_W(BANK_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .done    (done),
   .intr    (intr),
   .mem_req (mem_req),
   .mem_we  (mem_we),
   .irq_en  (irq_en),
   .bank    (bank)
);

// File: tb/bcopy_engine_test.sv
`timescale 1ns/1ps
module bcopy_engine_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        busy, done, intr;
   logic        opr_we = 1'b0;
   logic [2:0]  opr_sel = 3'd0;
   logic [15:0] opr_wdata = 16'd0;
   logic [15:0] opr_rdata;
   logic        mem_req, mem_we;
   logic [17:0] mem_addr;
   logic [15:0] mem_wdata;
   logic        mem_rvalid = 1'b0;
   logic [15:0] mem_rdata = 16'd0;
   logic        irq_req = 1'b0;
   logic        irq_en = 1'b0;
   logic [3:0]  bank;

   int n_chk = 0;
   int n_err = 0;
   int wr_cnt = 0;
   int rd_cnt = 0;
   int overlap = 0;
   logic prev_rd = 1'b0;
   logic [15:0] mem [1024];

   always #10 clk = ~clk;

   bcopy_engine uut (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .intr(intr),
      .opr_we(opr_we), .opr_sel(opr_sel), .opr_wdata(opr_wdata), .opr_rdata(opr_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .irq_req(irq_req), .irq_en(irq_en),
      .bank(bank)
   );

   function automatic int idx(input logic [17:0] a);
      return int'({a[17:16], a[7:0]});
   endfunction

   // memory model: one-cycle read latency
   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (mem_req && prev_rd) overlap <= overlap + 1;
      prev_rd <= mem_req && !mem_we;
      if (mem_req) begin
         if (mem_we) begin
            mem[idx(mem_addr)] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
         end else begin
            mem_rdata  <= mem[idx(mem_addr)];
            mem_rvalid <= 1'b1;
            rd_cnt     <= rd_cnt + 1;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_op(input logic [2:0] s, input logic [15:0] v);
      @(negedge clk);
      opr_we = 1'b1; opr_sel = s; opr_wdata = v;
      @(negedge clk);
      opr_we = 1'b0;
   endtask

   task automatic rd_op(input logic [2:0] s, output logic [15:0] v);
      @(negedge clk);
      opr_sel = s;
      #1 v = opr_rdata;
   endtask

   task automatic load_all(input logic [15:0] sl, input logic [1:0] sh, input logic [15:0] c,
                           input logic [15:0] dl, input logic [1:0] dh, input logic [3:0] b);
      wr_op(3'd0, sl); wr_op(3'd1, 16'(sh)); wr_op(3'd2, c);
      wr_op(3'd3, dl); wr_op(3'd4, 16'(dh)); wr_op(3'd5, 16'(b));
   endtask

   // start and count falling edges from the first busy cycle to the exit pulse
   task automatic run(input string req, input int exp_k, input logic exp_intr,
                      input logic [3:0] exp_bank_run, input logic [3:0] exp_bank_exit,
                      input logic poke);
      int k;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      k = 0;
      chk({req, " bank in run (R3)"}, 32'(bank), 32'(exp_bank_run));
      while (!(done || intr) && k < 3000) begin
         if (poke && k == 2) begin
            start = 1'b1; opr_we = 1'b1; opr_sel = 3'd2; opr_wdata = 16'h0055;
         end else begin
            start = 1'b0; opr_we = 1'b0;
         end
         @(negedge clk);
         k++;
      end
      start = 1'b0; opr_we = 1'b0;
      chk({req, " exit cycle"}, 32'(k), 32'(exp_k));
      chk({req, " exit kind (R11)"}, {30'd0, done, intr}, exp_intr ? 32'd1 : 32'd2);
      chk({req, " bank at exit (R10)"}, 32'(bank), 32'(exp_bank_exit));
      @(negedge clk);
      chk({req, " pulse ends (R11)"}, {29'd0, busy, done, intr}, 32'd0);
   endtask

   task automatic t_reset;
      logic [15:0] v;
      chk("R1 reset busy/done/intr/req", {28'd0, busy, done, intr, mem_req}, 32'd0);
      for (int s = 0; s < 6; s++) begin
         rd_op(3'(s), v);
         chk("R1 reset readback", 32'(v), 32'd0);
      end
   endtask

   task automatic t_loadback;
      logic [15:0] v;
      load_all(16'h1234, 2'd3, 16'h0777, 16'hBEEF, 2'd1, 4'h9);
      rd_op(3'd0, v); chk("R1 src lo", 32'(v), 32'h1234);
      rd_op(3'd1, v); chk("R1 src hi", 32'(v), 32'h3);
      rd_op(3'd2, v); chk("R1 count",  32'(v), 32'h0777);
      rd_op(3'd3, v); chk("R1 dst lo", 32'(v), 32'hBEEF);
      rd_op(3'd4, v); chk("R1 dst hi", 32'(v), 32'h1);
      rd_op(3'd5, v); chk("R1 bank",   32'(v), 32'h9);
   endtask

   task automatic t_basic;
      logic [15:0] v;
      int w0;
      for (int i = 0; i < 6; i++) mem[256 + 16 + i] = 16'hA000 + 16'(i);
      mem[512 + 64 + 5] = 16'h5A5A;
      w0 = wr_cnt;
      load_all(16'h0010, 2'd1, 16'd5, 16'h0040, 2'd2, 4'hA);
      run("R5 basic", 21, 1'b0, 4'h6, 4'hA, 1'b0);
      for (int i = 0; i < 5; i++)
         chk("R5 copied word", 32'(mem[512 + 64 + i]), 32'(16'hA000 + 16'(i)));
      chk("R5 word past end untouched", 32'(mem[512 + 64 + 5]), 32'h5A5A);
      chk("R5 write count", 32'(wr_cnt - w0), 32'd5);
      rd_op(3'd0, v); chk("R6 src advanced", 32'(v), 32'h0015);
      rd_op(3'd3, v); chk("R6 dst advanced", 32'(v), 32'h0045);
      rd_op(3'd2, v); chk("R5 count drained", 32'(v), 32'd0);
   endtask

   task automatic t_zero;
      int r0, w0;
      r0 = rd_cnt; w0 = wr_cnt;
      load_all(16'h0000, 2'd0, 16'd0, 16'h0000, 2'd3, 4'h2);
      run("R4 zero count", 1, 1'b0, 4'h3, 4'h2, 1'b0);
      chk("R4 no accesses", 32'((rd_cnt - r0) + (wr_cnt - w0)), 32'd0);
   endtask

   task automatic t_wrap;
      logic [15:0] v;
      mem[254] = 16'h1111; mem[255] = 16'h2222; mem[0] = 16'h3333;
      load_all(16'hFFFE, 2'd0, 16'd3, 16'h0080, 2'd3, 4'h0);
      run("R6 wrap", 13, 1'b0, 4'h3, 4'h0, 1'b0);
      chk("R6 wrap word0", 32'(mem[768 + 128]), 32'h1111);
      chk("R6 wrap word1", 32'(mem[768 + 129]), 32'h2222);
      chk("R6 wrap word2", 32'(mem[768 + 130]), 32'h3333);
      rd_op(3'd0, v); chk("R6 src lo wrapped", 32'(v), 32'h0001);
      rd_op(3'd1, v); chk("R6 src hi kept", 32'(v), 32'h0);
   endtask

   task automatic t_irq_disabled;
      for (int i = 0; i < 3; i++) mem[32 + i] = 16'hC100 + 16'(i);
      irq_req = 1'b1; irq_en = 1'b0;
      load_all(16'h0020, 2'd0, 16'd3, 16'h0060, 2'd0, 4'h5);
      run("R8 irq disabled", 13, 1'b0, 4'h0, 4'h5, 1'b0);
      irq_req = 1'b0;
      for (int i = 0; i < 3; i++)
         chk("R8 copy complete", 32'(mem[96 + i]), 32'(16'hC100 + 16'(i)));
   endtask

   task automatic t_interrupt;
      logic [15:0] v;
      int w0;
      for (int i = 0; i < 5; i++) mem[256 + 160 + i] = 16'hD000 + 16'(i);
      mem[768 + 200 + 4] = 16'h7777;
      w0 = wr_cnt;
      irq_req = 1'b1; irq_en = 1'b1;
      load_all(16'h00A0, 2'd1, 16'd4, 16'h00C8, 2'd3, 4'hC);
      run("R7 first abort", 4, 1'b1, 4'h7, 4'hC, 1'b0);
      rd_op(3'd2, v); chk("R7 count after abort", 32'(v), 32'd3);
      rd_op(3'd0, v); chk("R7 src after abort", 32'(v), 32'h00A1);
      rd_op(3'd3, v); chk("R7 dst after abort", 32'(v), 32'h00C9);
      for (int j = 0; j < 3; j++) run("R9 resume abort", 4, 1'b1, 4'h7, 4'hC, 1'b0);
      run("R9 final resume", 1, 1'b0, 4'h7, 4'hC, 1'b0);
      irq_req = 1'b0; irq_en = 1'b0;
      for (int i = 0; i < 4; i++)
         chk("R9 resumed word", 32'(mem[768 + 200 + i]), 32'(16'hD000 + 16'(i)));
      chk("R9 no extra word", 32'(mem[768 + 204]), 32'h7777);
      chk("R9 writes exactly once", 32'(wr_cnt - w0), 32'd4);
   endtask

   task automatic t_busy_poke;
      logic [15:0] v;
      int w0;
      w0 = wr_cnt;
      load_all(16'h0030, 2'd0, 16'd3, 16'h0070, 2'd1, 4'h4);
      run("R2 busy poke", 13, 1'b0, 4'h1, 4'h4, 1'b1);
      rd_op(3'd2, v); chk("R2 count load ignored", 32'(v), 32'd0);
      chk("R2 no restart", 32'(wr_cnt - w0), 32'd3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_loadback();
      t_basic();
      t_zero();
      t_wrap();
      t_irq_disabled();
      t_interrupt();
      t_busy_poke();
      chk("R12 single outstanding access", 32'(overlap), 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule